// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block sits between a simple request port and a byte-level I2C engine. A single request names a 7-bit target device, an 8-bit register index, a direction (write or read) and, for writes, one data byte. The sequencer then walks a fixed script of byte commands to the engine and reports the outcome.

A write becomes three commands:

1. The device address with the write bit, opening with a start condition.
2. The register index.
3. The data byte, closing with a stop condition.

A read becomes four commands:

1. The device address with the write bit.
2. The register index.
3. The device address with the read bit, under a repeated start.
4. A single receive that the master answers with not-acknowledge and closes with a stop.

If the slave fails to acknowledge any byte the master sent, the sequencer gives up. It asks the engine for a bare stop, raises an error flag and returns to idle.

The controller is a Moore machine: every command field is decoded from the current state and the latched request alone. A command stays presented, unchanged, until the engine reports it finished. The next command appears one clock after that report.

Top module: `i2c_reg_seq`

## Requirements
- R1: While reset is held and after its release with no request, busy, done, err, cmd_valid and rdata are all 0, even if req_valid is high during reset.
- R2: The first command after a request is accepted has cmd_action = 0 (send; 1 = receive, 2 = stop only), cmd_start = 1, cmd_stop = 0, cmd_nack = 0 and cmd_data = {device address, 0}, with the address in bits 7:1.
- R3: The second command is a send with start and stop both 0 and cmd_data equal to the register index.
- R4: For a write, the third command is a send with start 0, stop 1 and cmd_data equal to the write byte. Once it is acknowledged, done pulses with err = 0.
- R5: For a read, the third command is a send with start 1 (repeated start), stop 0 and cmd_data = {device address, 1}.
- R6: For a read, the fourth command has cmd_action = 1, cmd_stop = 1, cmd_nack = 1 and cmd_start = 0. The byte on eng_rdata with its eng_done appears on rdata when done pulses. rdata changes on no other transaction.
- R7: A command stays on the command port with cmd_valid = 1 and all fields stable until eng_done. The sequencer advances only on eng_done, and for sent bytes only when eng_ack = 1.
- R8: When eng_ack = 0 with eng_done on any sent byte, the next command is a stop only: action 2, start 0, stop 1. When it completes, done pulses with err = 1. err returns to 0 when the next request is accepted.
- R9: A request is accepted only when busy is 0. busy rises the clock after acceptance and stays 1 through the single cycle in which done is 1. Requests made while busy do not change any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_dev | input | DEV_W | Target device address |
| req_reg | input | DATA_W | Register index |
| req_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Last transaction aborted on a missing acknowledge |
| rdata | output | DATA_W | Byte from the last completed read |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_action | output | 2 | 0 send, 1 receive, 2 stop only |
| cmd_start | output | 1 | Generate start or repeated start first |
| cmd_stop | output | 1 | Generate stop after the byte |
| cmd_nack | output | 1 | Master answers the received byte with not-acknowledge |
| cmd_data | output | DATA_W | Byte to send |
| eng_done | input | 1 | Engine finished the presented command (one cycle) |
| eng_ack | input | 1 | Slave acknowledged the sent byte |
| eng_rdata | input | DATA_W | Byte received by the engine |

## Verification
The assertions assume that the engine raises eng_done only while a command is presented and for one cycle per command. They also assume that eng_ack is meaningful only for send commands. The bench's engine model keeps to this: it waits for cmd_valid, holds the command for zero to two extra cycles, and then pulses eng_done exactly once. Requests during busy are driven only while a command is outstanding, and are dropped before the idle state returns. The sweep covers both directions, every position of a missing acknowledge, and a range of addresses and data bytes.

// File: rtl/i2c_seq_pkg.sv
// Package: shared encodings for the register access sequencer.
// Assumes: action codes are visible on the command port and decoded by the engine.
package i2c_seq_pkg;

    // Command kinds seen by the byte engine.
    typedef enum logic [1:0] {
        ACT_SEND = 2'd0,
        ACT_RECV = 2'd1,
        ACT_HALT = 2'd2
    } act_e;

    // Script positions of the controller.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEVW = 3'd1,
        ST_REG  = 3'd2,
        ST_WDAT = 3'd3,
        ST_DEVR = 3'd4,
        ST_RDAT = 3'd5,
        ST_HALT = 3'd6,
        ST_FIN  = 3'd7
    } st_e;

endpackage

// File: rtl/i2c_req_latch.sv
// Module: holds the accepted request for the length of one transaction.
// Assumes: load is asserted only when the controller accepts a request.
module i2c_req_latch #(
    parameter int DEV_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_read,
    input  logic [DEV_W-1:0]  in_dev,
    input  logic [DATA_W-1:0] in_reg,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              q_read,
    output logic [DEV_W-1:0]  q_dev,
    output logic [DATA_W-1:0] q_reg,
    output logic [DATA_W-1:0] q_wdata
);

    // Capture request fields on acceptance; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_read  <= 1'b0;
            q_dev   <= '0;
            q_reg   <= '0;
            q_wdata <= '0;
        end else if (load) begin
            q_read  <= in_read;
            q_dev   <= in_dev;
            q_reg   <= in_reg;
            q_wdata <= in_wdata;
        end
    end

endmodule

// File: rtl/i2c_seq_ctrl.sv
// Module: state register and next-state logic of the command script.
// Assumes: eng_done pulses once per presented command; eng_ack is valid with it.
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_read,
    input  logic eng_done,
    input  logic eng_ack,
    output st_e  state,
    output logic accept,
    output logic busy,
    output logic done
);

    st_e nxt;

    // Take a request only from idle.
    assign accept = req_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_FIN);

    // Select the next script position from the engine's report.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)   nxt = ST_DEVW;
            ST_DEVW: if (eng_done) nxt = eng_ack ? ST_REG : ST_HALT;
            ST_REG:  if (eng_done) nxt = !eng_ack ? ST_HALT : (is_read ? ST_DEVR : ST_WDAT);
            ST_WDAT: if (eng_done) nxt = eng_ack ? ST_FIN : ST_HALT;
            ST_DEVR: if (eng_done) nxt = eng_ack ? ST_RDAT : ST_HALT;
            ST_RDAT: if (eng_done) nxt = ST_FIN;
            ST_HALT: if (eng_done) nxt = ST_FIN;
            ST_FIN:                nxt = ST_IDLE;
            default:               nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/i2c_cmd_rom.sv
// Module: Moore decode of the command port from the current state and latched request.
// Assumes: DEV_W + 1 == DATA_W so that address plus direction bit fills one byte.
module i2c_cmd_rom
    import i2c_seq_pkg::*;
#(
    parameter int DEV_W  = 7,
    parameter int DATA_W = 8
) (
    input  st_e               state,
    input  logic [DEV_W-1:0]  dev,
    input  logic [DATA_W-1:0] regi,
    input  logic [DATA_W-1:0] wdata,
    output logic              valid,
    output act_e              action,
    output logic              start,
    output logic              stop,
    output logic              nack,
    output logic [DATA_W-1:0] data
);

    localparam int PAD_W = DATA_W - DEV_W - 1;

    logic [DATA_W-1:0] dev_wr;
    logic [DATA_W-1:0] dev_rd;

    generate
        if (PAD_W > 0) begin : g_pad
            assign dev_wr = {{PAD_W{1'b0}}, dev, 1'b0};
            assign dev_rd = {{PAD_W{1'b0}}, dev, 1'b1};
        end else begin : g_exact
            assign dev_wr = {dev, 1'b0};
            assign dev_rd = {dev, 1'b1};
        end
    endgenerate

    // Decode each script step into its command fields.
    always_comb begin
        valid  = 1'b0;
        action = ACT_SEND;
        start  = 1'b0;
        stop   = 1'b0;
        nack   = 1'b0;
        data   = '0;
        unique case (state)
            ST_DEVW: begin valid = 1'b1; start = 1'b1; data = dev_wr; end
            ST_REG:  begin valid = 1'b1; data = regi; end
            ST_WDAT: begin valid = 1'b1; stop = 1'b1; data = wdata; end
            ST_DEVR: begin valid = 1'b1; start = 1'b1; data = dev_rd; end
            ST_RDAT: begin valid = 1'b1; action = ACT_RECV; stop = 1'b1; nack = 1'b1; end
            ST_HALT: begin valid = 1'b1; action = ACT_HALT; stop = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_seq_status.sv
// Module: error flag and read-data register.
// Assumes: accept and state come from the controller of the same instance.
module i2c_seq_status
    import i2c_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               state,
    input  logic              accept,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);

    logic sending;

    // Steps whose byte must be acknowledged by the slave.
    assign sending = (state == ST_DEVW) || (state == ST_REG) ||
                     (state == ST_WDAT) || (state == ST_DEVR);

    // Clear the error on a new request, set it on a missing acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                               err <= 1'b0;
        else if (accept)                          err <= 1'b0;
        else if (sending && eng_done && !eng_ack) err <= 1'b1;
    end

    // Keep the byte returned by the receive step.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdata <= '0;
        else if (state == ST_RDAT && eng_done)     rdata <= eng_rdata;
    end

endmodule

// File: rtl/i2c_reg_seq.sv
// Module: top of the register access sequencer; connects latch, controller,
// command decode and status, and holds the protocol assertions.
// Assumes: the byte engine obeys the done/ack handshake described in the brief.
module i2c_reg_seq
    import i2c_seq_pkg::*;
#(
    parameter int DEV_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [DATA_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              cmd_valid,
    output logic [1:0]        cmd_action,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_nack,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [DATA_W-1:0] eng_rdata
);

    st_e               state;
    logic              accept;
    logic              q_read;
    logic [DEV_W-1:0]  q_dev;
    logic [DATA_W-1:0] q_reg;
    logic [DATA_W-1:0] q_wdata;
    act_e              act;

    i2c_req_latch #(.DEV_W(DEV_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .in_read(req_read), .in_dev(req_dev), .in_reg(req_reg), .in_wdata(req_wdata),
        .q_read(q_read), .q_dev(q_dev), .q_reg(q_reg), .q_wdata(q_wdata)
    );

    i2c_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_read(q_read),
        .eng_done(eng_done), .eng_ack(eng_ack),
        .state(state), .accept(accept), .busy(busy), .done(done)
    );

    i2c_cmd_rom #(.DEV_W(DEV_W), .DATA_W(DATA_W)) u_rom (
        .state(state), .dev(q_dev), .regi(q_reg), .wdata(q_wdata),
        .valid(cmd_valid), .action(act), .start(cmd_start), .stop(cmd_stop),
        .nack(cmd_nack), .data(cmd_data)
    );

    i2c_seq_status #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .err(err), .rdata(rdata)
    );

    assign cmd_action = act;

    // R1: nothing is presented or reported while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && !done));

    // R2: acceptance is followed by a start-flagged write-address send.
    p_first_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cmd_valid && cmd_start && !cmd_stop &&
                    cmd_action == ACT_SEND && cmd_data[0] == 1'b0));

    // R4: an acknowledged closing send ends the transaction cleanly.
    p_write_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_action == ACT_SEND && cmd_stop && eng_done && eng_ack)
        |=> (done && !err));

    // R6: the receive step always closes with not-acknowledge and stop.
    p_recv_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_action == ACT_RECV) |-> (cmd_stop && cmd_nack && !cmd_start));

    // R7: an unfinished command is held unchanged.
    p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done) |=> (cmd_valid && $stable(cmd_data) &&
            $stable(cmd_action) && $stable(cmd_start) && $stable(cmd_stop)));

    // R8: a missing acknowledge on a send leads to a stop-only command.
    p_nack_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_action == ACT_SEND && eng_done && !eng_ack)
        |=> (cmd_valid && cmd_action == ACT_HALT && cmd_stop && !cmd_start));

    // R8: the stop-only command ends with the error flag raised.
    p_halt_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_action == ACT_HALT && eng_done) |=> (done && err));

    // R9: done lasts one cycle and is followed by idle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/sim_i2c_reg_seq.sv
module sim_i2c_reg_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_read = 1'b0;
    logic [6:0] req_dev = '0;
    logic [7:0] req_reg = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, err, cmd_valid, cmd_start, cmd_stop, cmd_nack;
    logic [1:0] cmd_action;
    logic [7:0] rdata, cmd_data;
    logic       eng_done = 1'b0;
    logic       eng_ack = 1'b0;
    logic [7:0] eng_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_rd = 8'h00;
    logic [7:0] cur_dev;
    logic [7:0] cur_reg;
    logic [7:0] cur_wd;

    always #4 clk = ~clk;

    i2c_reg_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .cmd_valid(cmd_valid), .cmd_action(cmd_action), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_nack(cmd_nack), .cmd_data(cmd_data),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Engine model: wait for a command, compare it, hold, then finish it.
    task automatic serve(input string tag, input logic [1:0] ea, input logic es,
                         input logic ep, input logic en, input logic cd,
                         input logic [7:0] ed, input logic ack,
                         input logic [7:0] rb, input int dly);
        logic [7:0] first;
        int t = 0;
        while (!cmd_valid && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " R7 command presented"}, cmd_valid, 1'b1);
        chk({tag, " action"}, cmd_action, ea);
        chk({tag, " start"}, cmd_start, es);
        chk({tag, " stop"}, cmd_stop, ep);
        chk({tag, " nack"}, cmd_nack, en);
        if (cd) chk({tag, " data"}, cmd_data, ed);
        first = cmd_data;
        for (int d = 0; d < dly; d++) begin
            req_valid = 1'b1;            // R9: ignored while busy
            req_dev   = ~req_dev;
            req_read  = ~req_read;
            @(negedge clk);
            chk({tag, " R7 hold"}, {cmd_valid, cmd_action, cmd_data}, {1'b1, ea, first});
        end
        req_valid = 1'b0;
        eng_done  = 1'b1;
        eng_ack   = ack;
        eng_rdata = rb;
        @(negedge clk);
        eng_done  = 1'b0;
        eng_ack   = 1'b0;
    endtask

    task automatic run(input logic rd, input int npos, input logic [6:0] dv,
                       input logic [7:0] rg, input logic [7:0] wd,
                       input logic [7:0] rb, input int dly);
        logic fail_nack;
        req_valid = 1'b1;
        req_read  = rd;
        req_dev   = dv;
        req_reg   = rg;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after accept", busy, 1'b1);
        chk("R8 err cleared on accept", err, 1'b0);
        fail_nack = 1'b0;
        serve("R2 dev write", 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, {dv, 1'b0}, npos != 1, 8'h00, dly);
        if (npos == 1) fail_nack = 1'b1;
        if (!fail_nack) begin
            serve("R3 reg", 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, rg, npos != 2, 8'h00, (dly + 1) % 3);
            if (npos == 2) fail_nack = 1'b1;
        end
        if (!fail_nack && !rd) begin
            serve("R4 wdata", 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, wd, npos != 3, 8'h00, dly);
            if (npos == 3) fail_nack = 1'b1;
        end
        if (!fail_nack && rd) begin
            serve("R5 dev read", 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, {dv, 1'b1}, npos != 3, 8'h00, dly);
            if (npos == 3) fail_nack = 1'b1;
            if (!fail_nack) begin
                serve("R6 receive", 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, dv[0], rb, (dly + 2) % 3);
                exp_rd = rb;
            end
        end
        if (fail_nack)
            serve("R8 stop only", 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, dly);
        chk("R9 done pulse", {busy, done}, 2'b11);
        chk(fail_nack ? "R8 err set" : "R4 err clear", err, fail_nack);
        chk("R6 read data", rdata, exp_rd);
        @(negedge clk);
        chk("R9 done one cycle", {busy, done, cmd_valid}, 3'b000);
    endtask

    initial begin
        req_valid = 1'b1;                // R1: request during reset ignored
        repeat (3) @(negedge clk);
        chk("R1 reset state", {busy, done, err, cmd_valid, rdata}, 12'h000);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", {busy, done, err, cmd_valid, rdata}, 12'h000);
        for (int k = 0; k < 6; k++) begin
            for (int rd = 0; rd < 2; rd++) begin
                for (int np = 0; np < 4; np++) begin
                    cur_dev = 8'((k * 37 + np * 11 + rd * 5 + 3) & 8'h7f);
                    cur_reg = 8'(k * 53 + np * 29 + rd + 17);
                    cur_wd  = 8'(k * 71 + np * 13 + 200);
                    run(rd[0], np, cur_dev[6:0], cur_reg, cur_wd,
                        8'(cur_wd ^ 8'h5a), (k + np) % 3);
                    @(negedge clk);
                end
            end
        end
        // Edge values: all-ones and all-zero addresses and data.
        run(1'b0, 0, 7'h7f, 8'hff, 8'hff, 8'h00, 0);
        run(1'b1, 0, 7'h00, 8'h00, 8'h00, 8'hff, 0);
        run(1'b1, 0, 7'h7f, 8'hff, 8'h00, 8'h00, 2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule